// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Three tables of 2-bit saturating counters sit inside it. A bimodal table is indexed only by the branch address. A global table is indexed by the branch address XORed with a global history of recent outcomes. A chooser table, also indexed by the branch address, decides per branch which of the two guesses is used. The front end asks for a prediction on the lookup port. The back end reports each resolved branch on the update port, together with the guesses and the history checkpoint that the lookup returned.

The history register takes in each predicted outcome as soon as a lookup is accepted. When a resolved branch turns out to be mispredicted, the history is rebuilt from the checkpoint carried by the update, with the true outcome appended. After reset the block walks every table entry and sets it to weakly not-taken. During that walk both ports are held not ready.

Back-pressure rules: a lookup is accepted in a cycle where `lk_valid` and `lk_ready` are both high. The answer is given in that same cycle and flagged by `pred_valid`. There is no output stall, so the consumer must take the answer when it is offered. An update is accepted when `up_valid` and `up_ready` are both high. Both ready signals are low only during the initialisation walk. Once they rise they stay high.

Top module: `tourn_bpred`

## Requirements
- R1: After reset release, `lk_ready` and `up_ready` stay low for exactly 2^max(BIDX_W,GIDX_W) clock edges. They then rise and stay high. `pred_hist` reads zero after reset.
- R2: Once initialisation ends, every counter holds 1, so a branch that has never been updated predicts not-taken from both components, and the bimodal guess is the one selected.
- R3: Counters saturate in the range 0..3. A resolved taken branch adds one and a not-taken branch subtracts one. Values 2 and 3 mean taken, values 0 and 1 mean not-taken.
- R4: The bimodal and chooser entries are selected by `pc[BIDX_W-1:0]`.
- R5: The global entry is selected by `pc[GIDX_W-1:0]` XOR the history zero-extended to GIDX_W bits. An update uses its own `up_hist` in place of the live history.
- R6: `pred_taken` equals the global guess when the chooser counter is 2 or 3, and the bimodal guess otherwise.
- R7: The chooser counter steps up (toward global) when only the global guess was right. It steps down when only the bimodal guess was right. It is unchanged when both guesses were right or both were wrong.
- R8: An accepted lookup shifts `pred_taken` into bit 0 of the history. Older bits move up by one place and the oldest bit is dropped.
- R9: An accepted update with `up_pred != up_taken` sets the history to `{up_hist[HIST_W-2:0], up_taken}`. This takes priority over a lookup accepted in the same cycle.
- R10: An accepted update with `up_pred == up_taken` does not alter the history.
- R11: While the ready signals are low, `pred_valid` stays low and lookups and updates have no effect on the history or the counters.
- R12: A lookup accepted in the same cycle as an update to the same entries sees the counter values from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_pc | input | PC_W | Branch address to predict |
| pred_valid | output | 1 | Prediction outputs are meaningful this cycle |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component guess |
| pred_glb | output | 1 | Global component guess |
| pred_hist | output | HIST_W | History before this lookup (checkpoint) |
| up_valid | input | 1 | Resolution report |
| up_ready | output | 1 | Update can be accepted |
| up_pc | input | PC_W | Resolved branch address |
| up_taken | input | 1 | Actual outcome |
| up_pred | input | 1 | Final prediction given at lookup |
| up_bim | input | 1 | Bimodal guess given at lookup |
| up_glb | input | 1 | Global guess given at lookup |
| up_hist | input | HIST_W | History checkpoint given at lookup |

## Verification
A small configuration (16 bimodal/chooser entries, 32 global entries, 4-bit history) is driven with several outcome patterns against an arithmetic model kept in the bench. Fixed per-address outcomes favour the bimodal side. Outcomes derived from history bits favour the global side and move the chooser the other way. Pseudo-random outcomes mix both and cover aliasing across the index XOR. A counter ramp on a single address separates saturation from wrap-around. Back-to-back lookups followed by a late mispredicted update, and a lookup and an update landing in the same cycle, distinguish checkpoint restore from a plain shift and show whether the lookup read the table before or after the write.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'd1;

  // saturating step of a 2-bit direction counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tbp_init_seq.sv
module tbp_init_seq #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (&idx) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table import tbp_pkg::*; #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_val,
  input  logic [IDX_W-1:0] up_idx,
  output ctr_t             up_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_val
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  assign rd_val = mem[rd_idx];
  assign up_val = mem[up_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end
endmodule

// File: rtl/tbp_hist.sv
module tbp_hist #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         restore_en,
  input  logic [W-1:0] restore_base,
  input  logic         restore_bit,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)          hist <= '0;
    else if (restore_en) hist <= {restore_base[W-2:0], restore_bit};
    else if (shift_en)   hist <= {hist[W-2:0], shift_bit};
  end
endmodule

// File: rtl/tourn_bpred.sv
module tourn_bpred import tbp_pkg::*; #(
  parameter int PC_W   = 32,
  parameter int BIDX_W = 10,
  parameter int GIDX_W = 12,
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_bim,
  output logic              pred_glb,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic              up_pred,
  input  logic              up_bim,
  input  logic              up_glb,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int SWEEP_W = (BIDX_W > GIDX_W) ? BIDX_W : GIDX_W;

  logic               busy;
  logic [SWEEP_W-1:0] sweep_idx;
  logic               lk_fire, up_fire, up_miss;
  logic [HIST_W-1:0]  ghist;

  logic [BIDX_W-1:0] lk_bidx, up_bidx, b_wr_idx;
  logic [GIDX_W-1:0] lk_gidx, up_gidx, g_wr_idx;

  ctr_t bim_rd, glb_rd, cho_rd;
  ctr_t bim_cur, glb_cur, cho_cur;
  ctr_t bim_new, glb_new, cho_new;
  ctr_t bim_wr, glb_wr, cho_wr;
  logic bim_ok, glb_ok, tab_we;

  logic unused_pc_hi;
  assign unused_pc_hi = ^{lk_pc[PC_W-1:SWEEP_W], up_pc[PC_W-1:SWEEP_W]};

  tbp_init_seq #(.IDX_W(SWEEP_W)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .idx   (sweep_idx)
  );

  assign lk_ready = !busy;
  assign up_ready = !busy;
  assign lk_fire  = lk_valid && !busy;
  assign up_fire  = up_valid && !busy;
  assign up_miss  = up_fire && (up_pred != up_taken);

  // index formation
  assign lk_bidx = lk_pc[BIDX_W-1:0];
  assign up_bidx = up_pc[BIDX_W-1:0];
  assign lk_gidx = lk_pc[GIDX_W-1:0] ^ GIDX_W'(ghist);
  assign up_gidx = up_pc[GIDX_W-1:0] ^ GIDX_W'(up_hist);

  // write path: init walk has priority over updates (updates are not ready then)
  assign tab_we   = busy || up_fire;
  assign b_wr_idx = busy ? sweep_idx[BIDX_W-1:0] : up_bidx;
  assign g_wr_idx = busy ? sweep_idx[GIDX_W-1:0] : up_gidx;

  assign bim_ok  = (up_bim == up_taken);
  assign glb_ok  = (up_glb == up_taken);
  assign bim_new = ctr_step(bim_cur, up_taken);
  assign glb_new = ctr_step(glb_cur, up_taken);
  assign cho_new = (bim_ok != glb_ok) ? ctr_step(cho_cur, glb_ok) : cho_cur;

  assign bim_wr = busy ? CTR_WEAK_NT : bim_new;
  assign glb_wr = busy ? CTR_WEAK_NT : glb_new;
  assign cho_wr = busy ? CTR_WEAK_NT : cho_new;

  tbp_ctr_table #(.IDX_W(BIDX_W)) u_bim (
    .clk(clk), .rd_idx(lk_bidx), .rd_val(bim_rd), .up_idx(up_bidx), .up_val(bim_cur),
    .wr_en(tab_we), .wr_idx(b_wr_idx), .wr_val(bim_wr)
  );

  tbp_ctr_table #(.IDX_W(BIDX_W)) u_cho (
    .clk(clk), .rd_idx(lk_bidx), .rd_val(cho_rd), .up_idx(up_bidx), .up_val(cho_cur),
    .wr_en(tab_we), .wr_idx(b_wr_idx), .wr_val(cho_wr)
  );

  tbp_ctr_table #(.IDX_W(GIDX_W)) u_glb (
    .clk(clk), .rd_idx(lk_gidx), .rd_val(glb_rd), .up_idx(up_gidx), .up_val(glb_cur),
    .wr_en(tab_we), .wr_idx(g_wr_idx), .wr_val(glb_wr)
  );

  tbp_hist #(.W(HIST_W)) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (lk_fire),
    .shift_bit    (pred_taken),
    .restore_en   (up_miss),
    .restore_base (up_hist),
    .restore_bit  (up_taken),
    .hist         (ghist)
  );

  assign pred_valid = lk_fire;
  assign pred_bim   = ctr_says_taken(bim_rd);
  assign pred_glb   = ctr_says_taken(glb_rd);
  assign pred_taken = ctr_says_taken(cho_rd) ? pred_glb : pred_bim;
  assign pred_hist  = ghist;
endmodule

// File: rtl/tourn_bpred_chk.sv
module tourn_bpred_chk #(
  parameter int HIST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_bim,
  input logic              pred_glb,
  input logic [HIST_W-1:0] pred_hist,
  input logic              up_valid,
  input logic              up_ready,
  input logic              up_taken,
  input logic              up_pred,
  input logic [HIST_W-1:0] up_hist
);
  logic lk_go, up_go, up_bad;
  assign lk_go  = lk_valid && lk_ready;
  assign up_go  = up_valid && up_ready;
  assign up_bad = up_go && (up_pred != up_taken);

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |=> lk_ready); // R1

  AST_PRED_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (pred_taken == pred_bim) || (pred_taken == pred_glb)); // R6

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_go && !up_bad) |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(pred_taken)}); // R8

  AST_HIST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    up_bad |=> pred_hist == {$past(up_hist[HIST_W-2:0]), $past(up_taken)}); // R9

  AST_HIST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_go && !up_bad) |=> $stable(pred_hist)); // R10

  AST_IDLE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |-> !pred_valid && (pred_hist == '0)); // R11
endmodule

bind tourn_bpred tourn_bpred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_bim(pred_bim),
  .pred_glb(pred_glb), .pred_hist(pred_hist), .up_valid(up_valid),
  .up_ready(up_ready), .up_taken(up_taken), .up_pred(up_pred), .up_hist(up_hist)
);

// File: tb/test_tourn_bpred.sv
`timescale 1ns/1ps
module test_tourn_bpred;
  localparam int PW = 8, BW = 4, GW = 5, HW = 4;
  localparam int DEPTH = 32;
  localparam int HMASK = (1 << HW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [PW-1:0] lk_pc = '0;
  logic pred_valid, pred_taken, pred_bim, pred_glb;
  logic [HW-1:0] pred_hist;
  logic up_valid = 1'b0, up_ready;
  logic [PW-1:0] up_pc = '0;
  logic up_taken = 1'b0, up_pred = 1'b0, up_bim = 1'b0, up_glb = 1'b0;
  logic [HW-1:0] up_hist = '0;

  int checks = 0, failures = 0;
  int bim_m [16], cho_m [16], glb_m [32];
  int hist_m = 0;
  int glb_chosen = 0;
  int lcg = 12345;

  always #2.5 clk = ~clk;

  tourn_bpred #(.PC_W(PW), .BIDX_W(BW), .GIDX_W(GW), .HIST_W(HW)) i_tourn_bpred (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_bim(pred_bim),
    .pred_glb(pred_glb), .pred_hist(pred_hist), .up_valid(up_valid), .up_ready(up_ready),
    .up_pc(up_pc), .up_taken(up_taken), .up_pred(up_pred), .up_bim(up_bim),
    .up_glb(up_glb), .up_hist(up_hist)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v, input bit t);
    if (t) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  function automatic int next_rand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  // apply a resolution to the model tables and history
  task automatic model_update(input int pc, input bit t, input bit pp, input bit pb,
                              input bit pg, input int h, input bit lk_same_cycle, input bit lk_pred);
    int bi, gi;
    bi = pc % 16;
    gi = (pc % 32) ^ h;
    bim_m[bi] = sat(bim_m[bi], t);
    glb_m[gi] = sat(glb_m[gi], t);
    if (pb == t && pg != t) cho_m[bi] = sat(cho_m[bi], 1'b0);
    if (pg == t && pb != t) cho_m[bi] = sat(cho_m[bi], 1'b1);
    if (pp != t) hist_m = ((h << 1) | int'(t)) & HMASK;
    else if (lk_same_cycle) hist_m = ((hist_m << 1) | int'(lk_pred)) & HMASK;
  endtask

  // called at a negedge with lk_pc/lk_valid already driven; checks the answer
  task automatic check_answer(input int pc, input string htag,
                              output bit p, output bit b, output bit g, output int h);
    int bi, gi;
    #1;
    bi = pc % 16;
    gi = (pc % 32) ^ hist_m;
    b = bim_m[bi] >= 2;
    g = glb_m[gi] >= 2;
    p = (cho_m[bi] >= 2) ? g : b;
    h = hist_m;
    if (cho_m[bi] >= 2 && b != g) glb_chosen++;
    chk(pred_valid == 1'b1, "R11", "pred_valid when ready", int'(pred_valid), 1);
    chk(pred_bim == b, "R4", "bimodal guess", int'(pred_bim), int'(b));
    chk(pred_glb == g, "R5", "global guess", int'(pred_glb), int'(g));
    chk(pred_taken == p, "R6", "final guess", int'(pred_taken), int'(p));
    chk(int'(pred_hist) == h, htag, "history checkpoint", int'(pred_hist), h);
  endtask

  task automatic look(input int pc, input string htag,
                      output bit p, output bit b, output bit g, output int h);
    lk_valid = 1'b1;
    lk_pc = PW'(pc);
    check_answer(pc, htag, p, b, g, h);
    hist_m = ((hist_m << 1) | int'(p)) & HMASK;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic upd(input int pc, input bit t, input bit pp, input bit pb, input bit pg, input int h);
    up_valid = 1'b1; up_pc = PW'(pc); up_taken = t; up_pred = pp;
    up_bim = pb; up_glb = pg; up_hist = HW'(h);
    @(negedge clk);
    up_valid = 1'b0;
    model_update(pc, t, pp, pb, pg, h, 1'b0, 1'b0);
  endtask

  task automatic look_and_upd(input int lpc, input int upc, input bit t, input bit pp,
                              input bit pb, input bit pg, input int h, input string tag);
    bit p, b, g; int hh;
    up_valid = 1'b1; up_pc = PW'(upc); up_taken = t; up_pred = pp;
    up_bim = pb; up_glb = pg; up_hist = HW'(h);
    lk_valid = 1'b1; lk_pc = PW'(lpc);
    check_answer(lpc, tag, p, b, g, hh);
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    model_update(upc, t, pp, pb, pg, h, 1'b1, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit p, b, g; int h, n, t;
    bit pa, ba, ga, pb2, bb, gb, pc2, bc, gc;
    int ha, hb, hc;
    for (int i = 0; i < 16; i++) begin bim_m[i] = 1; cho_m[i] = 1; end
    for (int i = 0; i < 32; i++) glb_m[i] = 1;

    repeat (3) @(negedge clk);
    chk(lk_ready == 1'b0 && up_ready == 1'b0, "R1", "ready in reset", int'(lk_ready), 0);
    // stimulus during the init walk must be ignored
    lk_valid = 1'b1; lk_pc = 8'd5;
    up_valid = 1'b1; up_pc = 8'd5; up_taken = 1'b1; up_pred = 1'b0;
    up_bim = 1'b0; up_glb = 1'b0; up_hist = 4'd9;
    rst_n = 1'b1;
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (lk_ready || n > 2 * DEPTH) break;
      #1;
      if (n == 3 || n == 20) begin
        chk(pred_valid == 1'b0, "R11", "pred_valid during init", int'(pred_valid), 0);
        chk(pred_hist == '0, "R11", "history during init", int'(pred_hist), 0);
      end
    end
    lk_valid = 1'b0; up_valid = 1'b0;
    chk(n == DEPTH, "R1", "init length", n, DEPTH);
    chk(up_ready == 1'b1, "R1", "update ready after init", int'(up_ready), 1);
    #1;
    chk(pred_hist == '0, "R1", "history after init", int'(pred_hist), 0);

    // R2: untouched entries (including pc 5 updated during init) predict not-taken
    for (int pc = 0; pc < 16; pc++) begin
      look(pc, "R2", p, b, g, h);
      chk(p == 1'b0 && pred_bim == 1'b0, "R2", "fresh entry guess", int'(p), 0);
    end

    // R3: saturation ramp on one address
    for (int k = 0; k < 10; k++) begin
      look(3, "R8", p, b, g, h);
      upd(3, (k < 5), p, b, g, h);
    end
    chk(bim_m[3] == 0, "R3", "model sanity after ramp", bim_m[3], 0);
    look(3, "R3", p, b, g, h);
    chk(pred_bim == 1'b0, "R3", "bimodal saturated low", int'(pred_bim), 0);
    upd(3, 1'b1, p, b, g, h);
    look(3, "R3", p, b, g, h);
    chk(pred_bim == 1'b0, "R3", "one step from 0 still not-taken", int'(pred_bim), 0);
    upd(3, 1'b1, p, b, g, h);

    // main sweep: several outcome patterns
    for (int phase = 0; phase < 4; phase++) begin
      for (int i = 0; i < 300; i++) begin
        int pc;
        pc = (phase == 1) ? (i % 4) * 16 + 1 : (next_rand() & 8'hff);
        look(pc, "R8", p, b, g, h);
        case (phase)
          0: t = (pc >> 2) & 1;
          1: t = (h ^ (h >> 1)) & 1;
          2: t = i & 1;
          default: t = next_rand() & 1;
        endcase
        upd(pc, t[0], p, b, g, h);
      end
    end
    chk(glb_chosen > 0, "R7", "chooser moved to global", glb_chosen, 1);

    // R9/R10: in-flight lookups, late mispredicted resolution of the oldest
    look(7, "R8", pa, ba, ga, ha);
    look(9, "R8", pb2, bb, gb, hb);
    look(11, "R8", pc2, bc, gc, hc);
    upd(7, pa, pa, ba, ga, ha);               // correct: history kept
    look(2, "R10", p, b, g, h);
    upd(2, p, p, b, g, h);
    upd(9, !pb2, pb2, bb, gb, hb);            // mispredict: restore
    look(4, "R9", p, b, g, h);
    upd(4, !p, p, b, g, h);
    look(6, "R9", p, b, g, h);

    // R12 and R9 priority: lookup and update on the same address in one cycle
    look(12, "R8", pa, ba, ga, ha);
    look_and_upd(12, 12, !pa, pa, ba, ga, ha, "R12");
    look(12, "R9", p, b, g, h);
    look_and_upd(13, 12, p, p, b, g, h, "R12");
    look(14, "R10", p, b, g, h);
    upd(14, p, p, b, g, h);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule